// File: doc/BRIEF.md
# External Interrupt Request Controller

This block takes one asynchronous external interrupt pin and turns it into one interrupt request line for a small CPU core. The pin is brought into the clock domain through a two-stage synchroniser. A detector then looks for falling edges, rising edges, both, or a falling edge together with a held-low level. The sensitivity and an enable bit sit in an 8-bit control register. Software may change those bits only while the CPU's global interrupt mask input is high.

A qualifying event sets a pending latch. The latch is built as a two-state machine with states `PEND_IDLE` and `PEND_HELD`. Transition `SET`: a qualifying event moves `PEND_IDLE` to `PEND_HELD`, and does so even while the enable bit is 0. Transition `ACK`: the acknowledge strobe moves `PEND_HELD` to `PEND_IDLE` when no new event arrives in the same cycle. Transition `FLUSH`: an accepted write that alters the sensitivity selection forces `PEND_IDLE` from either state. In every other case the state is kept.

The request output is the pending state, or an active low-level condition, gated by the enable bit. Masking on the CPU side is applied outside the block.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset the sensitivity field is 00, the enable bit is 1, nothing is pending, the request is low and the read-back value is 0x10.
- R2: After a pin change, the synchronised value is seen two clock edges later. In an edge mode the request rises on the third rising clock edge after the change. In level mode the low-level request rises on the second.
- R3: Sensitivity field {bit 6, bit 5}: 00 selects falling edge plus low level, 01 selects falling edge only, 10 selects rising edge only, 11 selects both edges.
- R4: A write with the mask input at 0 leaves bits 6, 5 and 4 unchanged. Bits 3..0 are plain storage and take every write whatever the mask.
- R5: An accepted write whose sensitivity field differs from the current one clears the pending latch. This takes priority over an event in the same cycle. A write that leaves the field as it is does not clear the latch.
- R6: A qualifying event seen while the enable bit is 0 is still latched. The request shows it once the enable bit is written to 1.
- R7: The acknowledge strobe clears the pending latch. In mode 00 the request stays high while the synchronised pin is low, whatever the latch holds.
- R8: If an acknowledge and a qualifying event fall in the same cycle, the latch stays set.
- R9: Read-back is {pending, bit 6, bit 5, enable, stored bits 3..0}. Bit 7 is read-only and writes to it are ignored.
- R10: The request equals (pending OR (mode 00 AND synchronised pin low)) AND enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (power-on or external) |
| irq_pin | input | 1 | Asynchronous external interrupt pin |
| cpu_imask | input | 1 | CPU global interrupt mask; 1 allows option writes |
| reg_wr | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read-back |
| irq_ack | input | 1 | Acknowledge strobe at start of servicing |
| irq_req | output | 1 | Interrupt request to the CPU |

## Verification
The assertions assume that `irq_ack`, `reg_wr` and `cpu_imask` are synchronous to `clk`. They also assume that `irq_pin` is low or high, never unknown, so that the synchroniser and detector outputs are defined. The bench changes every input only on the falling clock edge and drives the pin high throughout reset. Random pin toggles are mixed with write and acknowledge strobes at varied densities, so that edges, flushes and acknowledges do meet in the same cycle.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;

    // Sensitivity field encoding: {rise_sel, fall_sel}
    typedef enum logic [1:0] {
        SENSE_FALL_LOW = 2'b00,
        SENSE_FALL     = 2'b01,
        SENSE_RISE     = 2'b10,
        SENSE_BOTH     = 2'b11
    } sense_e;

    typedef enum logic {
        PEND_IDLE = 1'b0,
        PEND_HELD = 1'b1
    } pend_state_e;

    localparam int REG_W      = 8;
    localparam int STAT_BIT   = 7;
    localparam int RISE_BIT   = 6;
    localparam int FALL_BIT   = 5;
    localparam int EN_BIT     = 4;
    localparam int SPARE_W    = 4;

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int   STAGES    = 2,
    parameter logic RESET_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync,
    output logic pin_sync_d
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= RESET_VAL;
                else        chain <= pin_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {STAGES{RESET_VAL}};
                else        chain <= {chain[STAGES-2:0], pin_async};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pin_sync_d <= RESET_VAL;
        else        pin_sync_d <= chain[STAGES-1];
    end

    assign pin_sync = chain[STAGES-1];

endmodule

// File: rtl/irq_detect.sv
module irq_detect
    import ext_irq_pkg::*;
(
    input  sense_e mode,
    input  logic   pin_sync,
    input  logic   pin_sync_d,
    output logic   hit,
    output logic   level_low
);

    logic fell, rose;

    always_comb begin
        fell      = pin_sync_d & ~pin_sync;
        rose      = ~pin_sync_d & pin_sync;
        level_low = 1'b0;
        hit       = 1'b0;
        unique case (mode)
            SENSE_FALL_LOW: begin
                hit       = fell;
                level_low = ~pin_sync;
            end
            SENSE_FALL: hit = fell;
            SENSE_RISE: hit = rose;
            SENSE_BOTH: hit = fell | rose;
        endcase
    end

endmodule

// File: rtl/irq_cfg.sv
module irq_cfg
    import ext_irq_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cpu_imask,
    input  logic               reg_wr,
    input  logic [REG_W-1:0]   reg_wdata,
    output sense_e             mode,
    output logic               enable,
    output logic [SPARE_W-1:0] spare,
    output logic               flush
);

    logic   accept;
    sense_e new_mode;
    logic   unused_wbit;

    assign unused_wbit = reg_wdata[STAT_BIT];
    assign accept      = reg_wr & cpu_imask;
    assign new_mode    = sense_e'({reg_wdata[RISE_BIT], reg_wdata[FALL_BIT]});
    assign flush       = accept && (new_mode != mode);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode   <= SENSE_FALL_LOW;
            enable <= 1'b1;
        end else if (accept) begin
            mode   <= new_mode;
            enable <= reg_wdata[EN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      spare <= '0;
        else if (reg_wr) spare <= reg_wdata[SPARE_W-1:0];
    end

    a_r4_locked_when_unmasked: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && !cpu_imask) |=> ($stable(mode) && $stable(enable)));

endmodule

// File: rtl/irq_pend_fsm.sv
module irq_pend_fsm
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic hit,
    input  logic ack,
    input  logic flush,
    output logic pending
);

    pend_state_e state, state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= PEND_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            PEND_IDLE: begin
                if (!flush && hit) state_nx = PEND_HELD;          // SET
            end
            PEND_HELD: begin
                if (flush)             state_nx = PEND_IDLE;      // FLUSH
                else if (ack && !hit)  state_nx = PEND_IDLE;      // ACK
            end
        endcase
    end

    assign pending = (state == PEND_HELD);

    a_r5_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !pending);

    a_r7_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !hit && !flush) |=> !pending);

    a_r8_event_wins_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (hit && !flush) |=> pending);

    a_r6_held_without_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !ack && !flush) |=> pending);

endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
    import ext_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             irq_pin,
    input  logic             cpu_imask,
    input  logic             reg_wr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             irq_ack,
    output logic             irq_req
);

    logic               pin_s, pin_sd;
    logic               hit, level_low, flush, pending, enable;
    sense_e             mode;
    logic [SPARE_W-1:0] spare;

    irq_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(irq_pin),
        .pin_sync(pin_s), .pin_sync_d(pin_sd)
    );

    irq_detect u_detect (
        .mode(mode), .pin_sync(pin_s), .pin_sync_d(pin_sd),
        .hit(hit), .level_low(level_low)
    );

    irq_cfg u_cfg (
        .clk(clk), .rst_n(rst_n), .cpu_imask(cpu_imask), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .mode(mode), .enable(enable), .spare(spare),
        .flush(flush)
    );

    irq_pend_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .hit(hit), .ack(irq_ack), .flush(flush),
        .pending(pending)
    );

    assign irq_req   = (pending | level_low) & enable;
    assign reg_rdata = {pending, mode[1], mode[0], enable, spare};

    a_r10_gated_by_enable: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !irq_req);

    a_r7_level_follows_pin: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && mode == SENSE_FALL_LOW && !pin_s) |-> irq_req);

endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       irq_pin = 1'b1;
    logic       cpu_imask = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       irq_ack = 1'b0;
    logic       irq_req;

    int checks = 0;
    int errors = 0;

    // reference state
    logic       m_ff1, m_s, m_sd, m_en, m_pend;
    logic [1:0] m_mode;
    logic [3:0] m_low;

    ext_irq_ctrl u_ext_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .cpu_imask(cpu_imask),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_ack(irq_ack), .irq_req(irq_req)
    );

    always #10 clk = ~clk;  // 50 MHz

    function automatic logic exp_req();
        return (m_pend | (m_mode == 2'b00 && !m_s)) & m_en;
    endfunction

    function automatic logic [7:0] exp_rdata();
        return {m_pend, m_mode, m_en, m_low};
    endfunction

    task automatic model_reset();
        m_ff1 = 1; m_s = 1; m_sd = 1; m_en = 1; m_pend = 0;
        m_mode = 2'b00; m_low = 4'h0;
    endtask

    task automatic model_clock();
        logic fell, rose, hit, accept, flush;
        fell   = m_sd & ~m_s;
        rose   = ~m_sd & m_s;
        case (m_mode)
            2'b00, 2'b01: hit = fell;
            2'b10:        hit = rose;
            default:      hit = fell | rose;
        endcase
        accept = reg_wr & cpu_imask;
        flush  = accept && (reg_wdata[6:5] != m_mode);
        if (flush)        m_pend = 0;
        else if (hit)     m_pend = 1;
        else if (irq_ack) m_pend = 0;
        if (accept) begin
            m_mode = reg_wdata[6:5];
            m_en   = reg_wdata[4];
        end
        if (reg_wr) m_low = reg_wdata[3:0];
        m_sd = m_s; m_s = m_ff1; m_ff1 = irq_pin;
    endtask

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // one clock: inputs already applied; compare after the edge
    task automatic step(string tag);
        @(posedge clk);
        model_clock();
        @(negedge clk);
        check({tag, " req (R10)"}, {7'd0, irq_req}, {7'd0, exp_req()});
        check({tag, " rdata (R9)"}, reg_rdata, exp_rdata());
    endtask

    task automatic idle_inputs();
        reg_wr = 0; irq_ack = 0;
    endtask

    task automatic write_reg(logic [7:0] d, logic mask, string tag);
        reg_wr = 1; reg_wdata = d; cpu_imask = mask;
        step(tag);
        reg_wr = 0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #4000000;
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        check("R1 rdata", reg_rdata, 8'h10);
        check("R1 req", {7'd0, irq_req}, 8'd0);

        // R2 latency in falling-only mode (R3 code 01)
        write_reg(8'h30, 1'b1, "R3 set fall");
        irq_pin = 0;
        step("R2 e1"); check("R2 low after 1", {7'd0, irq_req}, 8'd0);
        step("R2 e2"); check("R2 low after 2", {7'd0, irq_req}, 8'd0);
        step("R2 e3"); check("R2 high after 3", {7'd0, irq_req}, 8'd1);

        // R8 ack with same-cycle event
        irq_pin = 1; step("R8 a"); step("R8 b");
        write_reg(8'h50, 1'b1, "R8 rise mode"); // flush, rise mode
        irq_pin = 0; step("R8 c"); step("R8 d");
        irq_pin = 1; step("R8 e"); step("R8 f");
        irq_ack = 1; step("R8 ack+edge"); irq_ack = 0;
        check("R8 still pending", {7'd0, reg_rdata[7]}, 8'd1);

        // R7 ack clears
        irq_ack = 1; step("R7 ack"); irq_ack = 0;
        check("R7 cleared", {7'd0, reg_rdata[7]}, 8'd0);

        // R4 locked when mask 0; spare bits still written
        write_reg(8'h0a, 1'b0, "R4 masked");
        check("R4 fields kept", reg_rdata, 8'h5a);

        // R6 disabled latch then enable (R3 code 11, both edges)
        write_reg(8'h60, 1'b1, "R6 disable");
        irq_pin = 0; repeat (3) step("R6 edge");
        check("R6 req low", {7'd0, irq_req}, 8'd0);
        check("R6 pend held", {7'd0, reg_rdata[7]}, 8'd1);
        write_reg(8'h70, 1'b1, "R6 enable");
        check("R6 req shown", {7'd0, irq_req}, 8'd1);

        // R5 change of sensitivity flushes; same value write does not
        write_reg(8'h70, 1'b1, "R5 same");
        check("R5 kept", {7'd0, reg_rdata[7]}, 8'd1);
        write_reg(8'h10, 1'b1, "R5 change");
        check("R5 flushed", {7'd0, reg_rdata[7]}, 8'd0);
        // R7 level mode: pin low holds request
        check("R7 level req", {7'd0, irq_req}, 8'd1);
        irq_pin = 1; repeat (3) step("R7 release");

        // random mix
        for (int i = 0; i < 4000; i++) begin
            irq_pin   = ($urandom % 4 == 0) ? ~irq_pin : irq_pin;
            cpu_imask = $urandom % 2;
            irq_ack   = ($urandom % 6 == 0);
            reg_wr    = ($urandom % 10 == 0);
            reg_wdata = 8'($urandom);
            step("R3 random");
        end
        idle_inputs();
        finish_run();
    end

endmodule